// File: doc/BRIEF.md
# Interrupt Cause and Mask Group

This block collects up to `WIDTH` interrupt sources into one group. Each source owns a bit in a cause register, set either by a hardware event input or by software. A mask register blocks chosen causes from the group interrupt line. A separate abort-enable register picks the causes that drive an abort-request line. Software reaches all state through a small synchronous register bus. Read data comes back one cycle after the request.

Software can change the mask and the cause without a read-modify-write. It writes ones to a set alias or a clear alias, and bits written as zero keep their value. Two modes are selected in a control register. Clear-on-read empties the cause bits that a cause read returns. Auto-mask sets the mask bit of every cause at the moment it raises the interrupt, so each source signals once until software unmasks it again.

Address map, on the 3-bit `bus_addr`:

| Addr | Register | Access |
|------|----------|--------|
| 0 | cause | read |
| 1 | cause set | write ones |
| 2 | cause clear | write ones |
| 3 | mask | read and write |
| 4 | mask clear | write ones |
| 5 | mask set | write ones |
| 6 | abort enable | read and write |
| 7 | control | read and write |

In the control register, bit 0 enables clear-on-read and bit 1 enables auto-mask.

Top module: `icm_group`

## Requirements
- R1: After reset, cause is all zeros, mask is all ones, abort-enable is zero, and the control register (bit 0 clear-on-read, bit 1 auto-mask) reads zero; `irq` and `abort_req` are low.
- R2: A write to address 1 (cause set) sets every cause bit whose `bus_wdata` bit is 1 and leaves the other cause bits unchanged.
- R3: A write to address 2 (cause clear) clears every cause bit whose `bus_wdata` bit is 1 and leaves the other cause bits unchanged.
- R4: A 1 on `hw_event[i]` sets cause bit i on that clock edge. This happens even when a cause clear, or a clear-on-read, hits the same bit in the same cycle.
- R5: A write to address 3 replaces the whole mask. A write to address 5 (mask set) sets the mask bits written as 1 and leaves the rest unchanged.
- R6: A write to address 4 (mask clear) clears every mask bit written as 1 and leaves the other mask bits unchanged.
- R7: `irq` is registered. One cycle after cause and mask change, it equals the OR over all bits of cause AND NOT mask.
- R8: With control bit 0 set, a read of address 0 returns the cause and clears every cause bit in the same cycle, except bits set by `hw_event` in that cycle.
- R9: With control bit 1 set, every cause bit that is set and unmasked has its mask bit set on the same edge on which `irq` rises. Each such source therefore gives a one-cycle `irq` pulse.
- R10: If a mask-clear write and an auto-mask hit the same cycle, the clear wins for the bits it targets. Auto-mask still sets the other bits.
- R11: `abort_req` is registered. One cycle after cause or abort-enable (address 6) changes, it equals the OR over all bits of cause AND abort-enable.
- R12: A read returns, one cycle after the request, the register at the requested address. Reads of the write-only addresses 1, 2, 4 and 5 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid the cycle after a read |
| hw_event | input | WIDTH | Hardware event per cause bit, level sampled each edge |
| irq | output | 1 | Group interrupt |
| abort_req | output | 1 | Abort request |

## Verification
The bench builds the block with `WIDTH` = 8, so all 256 cause and mask patterns fit in the sweeps. It sweeps every cause value against a derived mask for the interrupt. It sweeps every mask value through the clear and set aliases, and every cause value through clear-on-read. A 16-by-16 grid covers abort-enable against cause. Directed cases time the collisions: an event against a clear, and an unmask against an auto-mask in the same cycle.

// File: rtl/icm_pkg.sv
// Shared definitions for the interrupt cause/mask group.
// Assumes a 3-bit register address space.
package icm_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CAUSE     = 3'd0,
        A_CAUSE_SET = 3'd1,
        A_CAUSE_CLR = 3'd2,
        A_MASK      = 3'd3,
        A_MASK_CLR  = 3'd4,
        A_MASK_SET  = 3'd5,
        A_ABORT     = 3'd6,
        A_CTRL      = 3'd7
    } icm_addr_e;

    localparam int CTRL_COR_BIT  = 0;
    localparam int CTRL_AUTO_BIT = 1;
endpackage

// File: rtl/icm_decode.sv
// Register bus decoder: turns a single-cycle request into per-register
// write and read strobes. Assumes at most one request per cycle.
module icm_decode
    import icm_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_cause_set,
    output logic              wr_cause_clr,
    output logic              wr_mask,
    output logic              wr_mask_set,
    output logic              wr_mask_clr,
    output logic              wr_abort,
    output logic              wr_ctrl,
    output logic              rd_cause
);
    logic wr_any;
    logic rd_any;

    // Split the request into write and read qualifiers.
    always_comb begin
        wr_any = bus_valid & bus_write;
        rd_any = bus_valid & ~bus_write;
    end

    // One strobe per addressed register.
    always_comb begin
        wr_cause_set = wr_any && (bus_addr == A_CAUSE_SET);
        wr_cause_clr = wr_any && (bus_addr == A_CAUSE_CLR);
        wr_mask      = wr_any && (bus_addr == A_MASK);
        wr_mask_set  = wr_any && (bus_addr == A_MASK_SET);
        wr_mask_clr  = wr_any && (bus_addr == A_MASK_CLR);
        wr_abort     = wr_any && (bus_addr == A_ABORT);
        wr_ctrl      = wr_any && (bus_addr == A_CTRL);
        rd_cause     = rd_any && (bus_addr == A_CAUSE);
    end
endmodule

// File: rtl/icm_cause.sv
// Cause register. Order of updates per cycle: clear-on-read wipe, then
// write-one-to-clear, then software set and hardware events, so a set
// from either source always survives a clear in the same cycle.
module icm_cause #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic [WIDTH-1:0] clr_bits,
    input  logic [WIDTH-1:0] set_bits,
    input  logic [WIDTH-1:0] hw_event,
    output logic [WIDTH-1:0] cause_q
);
    logic [WIDTH-1:0] cause_d;

    // Next cause value with set taking priority over clear.
    always_comb begin
        cause_d = wipe ? '0 : cause_q;
        cause_d = cause_d & ~clr_bits;
        cause_d = cause_d | set_bits | hw_event;
    end

    // Cause storage, empty after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end
endmodule

// File: rtl/icm_mask.sv
// Mask register. A direct write replaces the mask. Otherwise set bits
// (software and auto-mask) are merged first and software clear bits
// are applied last, so an unmask wins over an auto-mask in the same cycle.
module icm_mask #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] set_bits,
    input  logic [WIDTH-1:0] auto_bits,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] mask_q
);
    logic [WIDTH-1:0] mask_d;

    // Next mask value.
    always_comb begin
        if (load) mask_d = load_val;
        else      mask_d = (mask_q | set_bits | auto_bits) & ~clr_bits;
    end

    // Mask storage, everything masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end
endmodule

// File: rtl/icm_group.sv
// One interrupt group: cause, mask, abort-enable and control registers
// behind a synchronous register bus, plus registered interrupt and abort
// outputs. Assumes WIDTH >= 2 so the control bits fit in a read word.
module icm_group
    import icm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  hw_event,
    output logic              irq,
    output logic              abort_req
);
    logic wr_cause_set, wr_cause_clr, wr_mask, wr_mask_set, wr_mask_clr;
    logic wr_abort, wr_ctrl, rd_cause;
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] abort_en_q;
    logic             cor_en;
    logic             auto_en;
    logic [WIDTH-1:0] pending;
    logic [WIDTH-1:0] auto_bits;
    logic [WIDTH-1:0] rdata_d;

    icm_decode u_dec (
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .wr_cause_set (wr_cause_set),
        .wr_cause_clr (wr_cause_clr),
        .wr_mask      (wr_mask),
        .wr_mask_set  (wr_mask_set),
        .wr_mask_clr  (wr_mask_clr),
        .wr_abort     (wr_abort),
        .wr_ctrl      (wr_ctrl),
        .rd_cause     (rd_cause)
    );

    icm_cause #(.WIDTH(WIDTH)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (rd_cause & cor_en),
        .clr_bits (wr_cause_clr ? bus_wdata : '0),
        .set_bits (wr_cause_set ? bus_wdata : '0),
        .hw_event (hw_event),
        .cause_q  (cause_q)
    );

    // Unmasked pending causes and the bits auto-mask would lock.
    always_comb begin
        pending   = cause_q & ~mask_q;
        auto_bits = auto_en ? pending : '0;
    end

    icm_mask #(.WIDTH(WIDTH)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_mask),
        .load_val  (bus_wdata),
        .set_bits  (wr_mask_set ? bus_wdata : '0),
        .auto_bits (auto_bits),
        .clr_bits  (wr_mask_clr ? bus_wdata : '0),
        .mask_q    (mask_q)
    );

    // Abort-enable and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_en_q <= '0;
            cor_en     <= 1'b0;
            auto_en    <= 1'b0;
        end else begin
            if (wr_abort) abort_en_q <= bus_wdata;
            if (wr_ctrl) begin
                cor_en  <= bus_wdata[CTRL_COR_BIT];
                auto_en <= bus_wdata[CTRL_AUTO_BIT];
            end
        end
    end

    // Read mux for the addressed register.
    always_comb begin
        rdata_d = '0;
        if (bus_valid && !bus_write) begin
            unique case (bus_addr)
                A_CAUSE: rdata_d = cause_q;
                A_MASK:  rdata_d = mask_q;
                A_ABORT: rdata_d = abort_en_q;
                A_CTRL: begin
                    rdata_d[CTRL_COR_BIT]  = cor_en;
                    rdata_d[CTRL_AUTO_BIT] = auto_en;
                end
                default: rdata_d = '0;
            endcase
        end
    end

    // Registered read data and group outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            irq       <= 1'b0;
            abort_req <= 1'b0;
        end else begin
            if (bus_valid && !bus_write) bus_rdata <= rdata_d;
            irq       <= |pending;
            abort_req <= |(cause_q & abort_en_q);
        end
    end
endmodule

// File: rtl/icm_group_chk.sv
// Property checker for icm_group, attached by bind. Watches the bus,
// the event inputs, the stored cause/mask and the interrupt output.
module icm_group_chk
    import icm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  hw_event,
    input logic [WIDTH-1:0]  cause_q,
    input logic [WIDTH-1:0]  mask_q,
    input logic              cor_en,
    input logic              auto_en,
    input logic              irq
);
    // R4: an event bit is present in cause on the next cycle.
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_event != '0) |=> ((cause_q & $past(hw_event)) == $past(hw_event)));

    // R3: a cause clear without events empties the targeted bits.
    a_r3_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_CAUSE_CLR && hw_event == '0)
        |=> ((cause_q & $past(bus_wdata)) == '0));

    // R6 and R10: unmasked bits stay unmasked even under auto-mask.
    a_r10_unmask_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_MASK_CLR)
        |=> ((mask_q & $past(bus_wdata)) == '0));

    // R7: irq follows the unmasked causes with one cycle of latency.
    a_r7_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(cause_q & ~mask_q)));

    // R8: a clear-on-read access without events leaves cause empty.
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == A_CAUSE && cor_en && hw_event == '0)
        |=> (cause_q == '0));

    // R9: auto-mask locks every pending unmasked cause.
    a_r9_auto_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !(bus_valid && bus_write &&
                      (bus_addr == A_MASK || bus_addr == A_MASK_CLR)))
        |=> ((mask_q & $past(cause_q & ~mask_q)) == $past(cause_q & ~mask_q)));
endmodule

bind icm_group icm_group_chk #(.WIDTH(WIDTH)) u_icm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hw_event  (hw_event),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .cor_en    (cor_en),
    .auto_en   (auto_en),
    .irq       (irq)
);

// File: tb/test_icm_group.sv
`timescale 1ns/1ps
module test_icm_group;
    localparam int W = 8;
    localparam logic [2:0] AC = 3'd0, ACS = 3'd1, ACC = 3'd2, AM = 3'd3,
                           AMC = 3'd4, AMS = 3'd5, AAB = 3'd6, ACT = 3'd7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] hw_event = '0;
    logic         irq;
    logic         abort_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    icm_group #(.WIDTH(W)) i_icm_group (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_event  (hw_event),
        .irq       (irq),
        .abort_req (abort_req)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; request occupies exactly one clock edge.
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 abort", {7'd0, abort_req}, 8'h00);
        rd(AC, r);  chk("R1 cause", r, 8'h00);
        rd(AM, r);  chk("R1 mask", r, 8'hFF);
        rd(AAB, r); chk("R1 abort_en", r, 8'h00);
        rd(ACT, r); chk("R1 ctrl", r, 8'h00);

        // R12: control readback and write-only addresses
        wr(ACT, 8'h03); rd(ACT, r); chk("R12 ctrl", r, 8'h03);
        wr(ACT, 8'h00);
        wr(ACS, 8'h11);
        rd(ACS, r); chk("R12 wo set", r, 8'h00);
        rd(ACC, r); chk("R12 wo clr", r, 8'h00);
        rd(AMC, r); chk("R12 wo mclr", r, 8'h00);
        rd(AMS, r); chk("R12 wo mset", r, 8'h00);

        // R2 R3 R5 R7: all cause values against a derived mask
        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] c, m, keep;
            c = v[7:0];
            m = {c[2:0], c[7:3]} ^ 8'hA5;
            keep = 8'h0F;
            wr(ACC, 8'hFF);
            wr(ACS, c | keep);
            wr(ACC, keep & ~c);
            wr(AM, m);
            @(negedge clk);
            chk("R7 irq", {7'd0, irq}, {7'd0, |(c & ~m)});
            rd(AC, r); chk("R2 R3 cause", r, c);
            rd(AM, r); chk("R5 mask", r, m);
        end

        // R5 R6: mask aliases over every starting mask
        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] m, cl, st;
            m = v[7:0];
            cl = m * 8'd7 + 8'd3;
            st = {m[0], m[7:1]} & 8'h33;
            wr(AM, m);
            wr(AMC, cl);
            rd(AM, r); chk("R6 mask clr", r, m & ~cl);
            wr(AMS, st);
            rd(AM, r); chk("R5 mask set", r, (m & ~cl) | st);
        end

        // R8: clear-on-read over every cause value
        wr(AM, 8'hFF);
        wr(ACC, 8'hFF);
        wr(ACT, 8'h01);
        for (int v = 0; v < 256; v++) begin
            wr(ACS, v[7:0]);
            rd(AC, r); chk("R8 first read", r, v[7:0]);
            rd(AC, r); chk("R8 second read", r, 8'h00);
        end
        // R8 R4: event during a clearing read survives
        wr(ACS, 8'h3C);
        hw_event = 8'h40;
        rd(AC, r); chk("R8 read value", r, 8'h3C);
        hw_event = 8'h00;
        wr(ACT, 8'h00);
        rd(AC, r); chk("R4 event vs read clear", r, 8'h40);

        // R4: event and cause clear on the same edge
        wr(ACC, 8'hFF);
        wr(ACS, 8'h7E);
        hw_event = 8'h81;
        wr(ACC, 8'hFF);
        hw_event = 8'h00;
        rd(AC, r); chk("R4 event vs clear", r, 8'h81);

        // R11: abort enable against cause
        for (int a = 0; a < 16; a++) begin
            for (int c = 0; c < 16; c++) begin
                logic [W-1:0] av, cv;
                av = {a[1:0], a[3:0], a[3:2]};
                cv = {c[3:0], c[3:0]} & 8'hC3 | {2'b00, c[3:0], 2'b00};
                wr(AAB, av);
                wr(ACC, 8'hFF);
                wr(ACS, cv);
                @(negedge clk);
                chk("R11 abort", {7'd0, abort_req}, {7'd0, |(av & cv)});
            end
        end
        wr(AAB, 8'h00);

        // R9: auto-mask yields a one-cycle pulse and locks the bit
        wr(ACC, 8'hFF);
        wr(AM, 8'h00);
        wr(ACT, 8'h02);
        hw_event = 8'h04;
        @(negedge clk);
        hw_event = 8'h00;
        @(negedge clk);
        chk("R9 irq pulse high", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R9 irq pulse low", {7'd0, irq}, 8'h00);
        rd(AM, r); chk("R9 mask locked", r, 8'h04);

        // R10: unmask meets auto-mask on the same edge
        wr(ACT, 8'h00);
        wr(ACC, 8'hFF);
        wr(AM, 8'hD7);
        wr(ACT, 8'h02);
        wr(ACS, 8'h28);
        wr(AMC, 8'h08);
        chk("R9 irq raised", {7'd0, irq}, 8'h01);
        rd(AM, r); chk("R10 clear wins", r, 8'hF7);
        chk("R10 irq still high", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R9 irq after relock", {7'd0, irq}, 8'h00);
        rd(AM, r); chk("R9 mask relocked", r, 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule